// File: doc/BRIEF.md
# Programmable Serial Bit-Clock Generator

This block makes the bit clock for a serial audio or telephony link. It divides the system clock by a programmable modulus, which is the value of an 8-bit divider field plus two. A direction field selects the role of the shared clock pin. As master, the block drives its generated clock out through an output enable. As slave, it releases the pin and forwards the externally supplied clock as the interface clock.

A power-saving enable freezes the divider and parks the generated clock low. A single-cycle strobe in the system clock domain marks every generated rising edge, so that shift logic in the same domain can act on it. The three fields sit in one 32-bit control word. A simple write port sets the word and a read port returns it.

The interface expects the clock pin direction to match the frame-sync pin direction. A registered flag reports when they disagree.

Top module: `bitclk_gen`

## Requirements
- R1: After reset the control word reads 0x0000_0100: divider field (bits 7:0) = 0, enable (bit 8) = 1, direction (bit 9) = 0 (slave).
- R2: Bits 31:10 of the control word always read 0, and writing ones to them changes nothing.
- R3: With a divider field value D of 1 or more, the generated clock has a period of D+2 system cycles. This holds from 3 up to 256 cycles for D = 254.
- R4: A divider field of 0 is clamped to 1, so the period is never shorter than 3 cycles.
- R5: Each period of modulus M starts with a high phase of floor(M/2) cycles, and the remaining cycles are low. An even M therefore gives a 50% duty cycle.
- R6: A new divider value takes effect only at the next terminal count. The period in progress keeps its old length, and no short pulse appears.
- R7: While enable is 0, the counter is held, the generated clock sits low and no strobes occur. After enable returns to 1, the generated clock rises on the second clock edge after the write, and it then runs full periods counted from zero.
- R8: With direction = 1 (master), pin_oe is 1 and pin_out and if_clk both carry the generated clock. With direction = 0 (slave), pin_oe and pin_out are 0 and if_clk follows pin_in.
- R9: dir_mismatch is registered. It is 1 in the cycle after the direction field differs from fs_dir, and 0 in the cycle after they agree.
- R10: rise_stb is high for exactly the first cycle of each high phase of the generated clock, once per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read data |
| fs_dir | input | 1 | Frame-sync pin direction setting (1 = output) |
| pin_in | input | 1 | Clock pin input from the pad |
| pin_out | output | 1 | Clock pin output value to the pad |
| pin_oe | output | 1 | Clock pin output enable |
| if_clk | output | 1 | Interface bit clock (generated or external) |
| rise_stb | output | 1 | One-cycle mark of each generated rising edge |
| dir_mismatch | output | 1 | Clock and frame-sync directions differ |

## Verification
On every cycle, the assertions check the following: the reserved bits stay zero, the generated clock stays parked after a disable, the strobe lines up with a rising edge, the pin role follows the written direction bit, and the mismatch flag tracks its inputs. Period length, high-phase length, the clamp of a zero divider and the deferral of a divider change until the terminal count depend on counting across whole periods. Only the bench scenarios show those, by timing the intervals between strobes.

// File: rtl/bclk_pkg.sv
package bclk_pkg;

  // Default geometry of the control word
  localparam int unsigned CTRL_W  = 32;
  localparam int unsigned DIVF_W  = 8;
  localparam int unsigned ENB_POS = 8;
  localparam int unsigned DIR_POS = 9;

  // Divider arithmetic: modulus = max(field, DIV_FLOOR) + MOD_BIAS
  localparam int unsigned DIV_FLOOR = 1;
  localparam int unsigned MOD_BIAS  = 2;

  // Reset value of the enable field
  localparam logic ENB_RST = 1'b1;

  typedef enum logic {
    ROLE_SLAVE  = 1'b0,
    ROLE_MASTER = 1'b1
  } pin_role_e;

endpackage

// File: rtl/bclk_ctrl_reg.sv
module bclk_ctrl_reg
  import bclk_pkg::*;
#(
  parameter int unsigned REG_W   = CTRL_W,
  parameter int unsigned DIV_W   = DIVF_W,
  parameter int unsigned EN_BIT  = ENB_POS,
  parameter int unsigned DIR_BIT = DIR_POS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [DIV_W-1:0] div_f,
  output logic             en_f,
  output pin_role_e        dir_f,
  output logic [REG_W-1:0] rdata
);

  // Fields are held in flops. Everything else in the word is constant zero.
  always_ff @(posedge clk) begin
    if (rst) begin
      div_f <= '0;
      en_f  <= ENB_RST;
      dir_f <= ROLE_SLAVE;
    end else if (we) begin
      div_f <= wdata[DIV_W-1:0];
      en_f  <= wdata[EN_BIT];
      dir_f <= pin_role_e'(wdata[DIR_BIT]);
    end
  end

  // Read word assembled bit by bit; reserved positions tie to zero
  for (genvar b = 0; b < REG_W; b++) begin : g_rd
    if (b < DIV_W) begin : g_div
      assign rdata[b] = div_f[b];
    end else if (b == EN_BIT) begin : g_en
      assign rdata[b] = en_f;
    end else if (b == DIR_BIT) begin : g_dir
      assign rdata[b] = dir_f;
    end else begin : g_rsvd
      assign rdata[b] = 1'b0;
    end
  end

  // Reserved write bits are deliberately dropped
  logic unused_wbits;
  assign unused_wbits = ^wdata;

endmodule

// File: rtl/bclk_divider.sv
module bclk_divider
  import bclk_pkg::*;
#(
  parameter int unsigned DIV_W  = DIVF_W,
  parameter int unsigned DMIN   = DIV_FLOOR,
  parameter int unsigned BIAS   = MOD_BIAS,
  localparam int unsigned CNT_W = DIV_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div_val,
  output logic             gen_clk,
  output logic             rise_stb
);

  localparam logic [CNT_W-1:0] MOD_RST = CNT_W'(DMIN + BIAS);

  logic [CNT_W-1:0] mod_new, mod_act, cnt_q;
  logic [CNT_W-1:0] cnt_n, mod_n, cnt_inc;
  logic             run_q, run_n, gen_n, stb_n, term;

  // Clamp the programmed field, then add the bias
  always_comb begin
    if (div_val < DIV_W'(DMIN)) begin
      mod_new = MOD_RST;
    end else begin
      mod_new = {1'b0, div_val} + CNT_W'(BIAS);
    end
  end

  assign cnt_inc = cnt_q + 1'b1;
  assign term    = (cnt_q == mod_act - 1'b1);

  always_comb begin
    cnt_n = cnt_q;
    mod_n = mod_act;
    run_n = run_q;
    gen_n = gen_clk;
    stb_n = 1'b0;
    if (!en) begin
      // Frozen: park low, rearm so the next enable starts from zero
      cnt_n = '0;
      run_n = 1'b0;
      gen_n = 1'b0;
    end else if (!run_q || term) begin
      // Period boundary: adopt the pending modulus and rise
      cnt_n = '0;
      mod_n = mod_new;
      run_n = 1'b1;
      gen_n = 1'b1;
      stb_n = 1'b1;
    end else begin
      cnt_n = cnt_inc;
      gen_n = (cnt_inc < (mod_act >> 1));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      mod_act  <= MOD_RST;
      run_q    <= 1'b0;
      gen_clk  <= 1'b0;
      rise_stb <= 1'b0;
    end else begin
      cnt_q    <= cnt_n;
      mod_act  <= mod_n;
      run_q    <= run_n;
      gen_clk  <= gen_n;
      rise_stb <= stb_n;
    end
  end

endmodule

// File: rtl/bclk_pin_ctl.sv
module bclk_pin_ctl
  import bclk_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  pin_role_e role,
  input  logic      fs_dir,
  input  logic      gen_clk,
  input  logic      pin_in,
  output logic      pin_out,
  output logic      pin_oe,
  output logic      if_clk,
  output logic      dir_mismatch
);

  logic is_master;
  assign is_master = (role == ROLE_MASTER);

  // Both terms come straight from flops, so the pad sees no added register lag
  assign pin_oe  = is_master;
  assign pin_out = is_master & gen_clk;

  // Interface clock selection; the slave path is passed through unaltered
  assign if_clk = is_master ? gen_clk : pin_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_mismatch <= 1'b0;
    end else begin
      dir_mismatch <= (is_master != fs_dir);
    end
  end

endmodule

// File: rtl/bitclk_gen.sv
module bitclk_gen
  import bclk_pkg::*;
#(
  parameter int unsigned REG_W   = CTRL_W,
  parameter int unsigned DIV_W   = DIVF_W,
  parameter int unsigned EN_BIT  = ENB_POS,
  parameter int unsigned DIR_BIT = DIR_POS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             fs_dir,
  input  logic             pin_in,
  output logic             pin_out,
  output logic             pin_oe,
  output logic             if_clk,
  output logic             rise_stb,
  output logic             dir_mismatch
);

  logic [DIV_W-1:0] div_f;
  logic             en_f;
  pin_role_e        dir_f;
  logic             gen_clk;

  bclk_ctrl_reg #(
    .REG_W  (REG_W),
    .DIV_W  (DIV_W),
    .EN_BIT (EN_BIT),
    .DIR_BIT(DIR_BIT)
  ) u_reg (
    .clk  (clk),
    .rst  (rst),
    .we   (reg_we),
    .wdata(reg_wdata),
    .div_f(div_f),
    .en_f (en_f),
    .dir_f(dir_f),
    .rdata(reg_rdata)
  );

  bclk_divider #(
    .DIV_W(DIV_W)
  ) u_div (
    .clk     (clk),
    .rst     (rst),
    .en      (en_f),
    .div_val (div_f),
    .gen_clk (gen_clk),
    .rise_stb(rise_stb)
  );

  bclk_pin_ctl u_pin (
    .clk         (clk),
    .rst         (rst),
    .role        (dir_f),
    .fs_dir      (fs_dir),
    .gen_clk     (gen_clk),
    .pin_in      (pin_in),
    .pin_out     (pin_out),
    .pin_oe      (pin_oe),
    .if_clk      (if_clk),
    .dir_mismatch(dir_mismatch)
  );

endmodule

// File: rtl/bitclk_gen_chk.sv
module bitclk_gen_chk #(
  parameter int unsigned REG_W   = 32,
  parameter int unsigned EN_BIT  = 8,
  parameter int unsigned DIR_BIT = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_we,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata,
  input logic             fs_dir,
  input logic             en_f,
  input logic             dir_f,
  input logic             gen_clk,
  input logic             rise_stb,
  input logic             pin_oe,
  input logic             pin_out,
  input logic             dir_mismatch
);

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[REG_W-1:DIR_BIT+1] == '0);

  // R7
  park_low_chk: assert property (@(posedge clk) disable iff (rst)
    !en_f |=> (!gen_clk && !rise_stb));

  // R10
  stb_edge_chk: assert property (@(posedge clk) disable iff (rst)
    rise_stb |-> (gen_clk && !$past(gen_clk)));

  // R10
  edge_stb_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gen_clk) |-> rise_stb);

  // R8
  master_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_wdata[DIR_BIT]) |=> pin_oe);

  // R8
  slave_release_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && !reg_wdata[DIR_BIT]) |=> (!pin_oe && !pin_out));

  // R9
  mismatch_set_chk: assert property (@(posedge clk) disable iff (rst)
    (dir_f != fs_dir) |=> dir_mismatch);

  // R9
  mismatch_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (dir_f == fs_dir) |=> !dir_mismatch);

  // R7
  en_follow_chk: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> (en_f == $past(reg_wdata[EN_BIT])));

endmodule

bind bitclk_gen bitclk_gen_chk #(
  .REG_W  (REG_W),
  .EN_BIT (EN_BIT),
  .DIR_BIT(DIR_BIT)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .reg_we      (reg_we),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .fs_dir      (fs_dir),
  .en_f        (en_f),
  .dir_f       (dir_f),
  .gen_clk     (gen_clk),
  .rise_stb    (rise_stb),
  .pin_oe      (pin_oe),
  .pin_out     (pin_out),
  .dir_mismatch(dir_mismatch)
);

// File: tb/bitclk_gen_tb.sv
`timescale 1ns/1ps
module bitclk_gen_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        fs_dir = 1'b1;
  logic        pin_in = 1'b0;
  logic        pin_out, pin_oe, if_clk, rise_stb, dir_mismatch;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bitclk_gen u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .fs_dir(fs_dir), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .if_clk(if_clk),
    .rise_stb(rise_stb), .dir_mismatch(dir_mismatch)
  );

  function automatic logic [31:0] word(input logic dir, input logic en,
                                       input logic [7:0] div);
    return {22'd0, dir, en, div};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act,
                     input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic wait_stb(input string req);
    int k = 0;
    do begin
      @(negedge clk); k++;
    end while (!rise_stb && k < 600);
    if (k >= 600) chk(0, req, 0, 1);
  endtask

  // Measure one full period starting at a strobe; returns period and high length
  task automatic measure(input string req, output int per, output int hi);
    int t0;
    bit fell = 0;
    bit ok = 1;
    wait_stb(req);
    t0 = cyc; hi = 1;
    if (!pin_out) ok = 0;
    do begin
      @(negedge clk);
      if (!rise_stb) begin
        if (pin_out && !fell) hi++;
        else if (pin_out && fell) ok = 0;
        else fell = 1;
      end
    end while (!rise_stb && (cyc - t0) < 600);
    per = cyc - t0;
    chk(ok, {req, " single high run"}, ok, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    // R1
    chk(reg_rdata == 32'h0000_0100, "R1 reset word", reg_rdata, 32'h100);
    chk(pin_oe == 1'b0, "R1 reset slave", pin_oe, 0);
  endtask

  task automatic t_reserved();
    wr(32'hFFFF_FFFF);
    @(negedge clk);
    // R2
    chk(reg_rdata == 32'h0000_03FF, "R2 reserved bits", reg_rdata, 32'h3FF);
  endtask

  task automatic t_modulus(input logic [7:0] d, input int m, input string req);
    int per, hi;
    wr(word(1'b1, 1'b1, d));
    wait_stb(req); wait_stb(req);
    measure(req, per, hi);
    chk(per == m, {req, " period"}, per, m);
    // R5
    chk(hi == m / 2, "R5 high phase", hi, m / 2);
  endtask

  task automatic t_no_runt();
    int t0, p1, p2;
    wr(word(1'b1, 1'b1, 8'd2));
    wait_stb("R6"); wait_stb("R6");
    t0 = cyc;
    wr(word(1'b1, 1'b1, 8'd6));
    wait_stb("R6");
    p1 = cyc - t0; t0 = cyc;
    wait_stb("R6");
    p2 = cyc - t0;
    // R6: the period in progress stays 4, the next one is 8
    chk(p1 == 4, "R6 old period kept", p1, 4);
    chk(p2 == 8, "R6 new period", p2, 8);
  endtask

  task automatic t_disable();
    bit quiet = 1;
    int per, hi;
    wr(word(1'b1, 1'b0, 8'd3));
    repeat (2) @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pin_out || rise_stb) quiet = 0;
    end
    // R7
    chk(quiet, "R7 frozen low", quiet, 1);
    wr(word(1'b1, 1'b1, 8'd3));
    @(negedge clk);
    chk(rise_stb == 1'b0, "R7 restart latency", rise_stb, 0);
    @(negedge clk);
    chk(rise_stb == 1'b1 && pin_out == 1'b1, "R7 restart rise", rise_stb, 1);
    measure("R7", per, hi);
    chk(per == 5, "R7 restart period", per, 5);
  endtask

  task automatic t_pins();
    fs_dir = 1'b0;
    wr(word(1'b0, 1'b1, 8'd1));
    @(negedge clk);
    // R8
    chk(pin_oe == 1'b0 && pin_out == 1'b0, "R8 slave release", pin_oe, 0);
    pin_in = 1'b1; #1;
    chk(if_clk == 1'b1, "R8 slave pass high", if_clk, 1);
    pin_in = 1'b0; #1;
    chk(if_clk == 1'b0, "R8 slave pass low", if_clk, 0);
    fs_dir = 1'b1;
    wr(word(1'b1, 1'b1, 8'd1));
    @(negedge clk);
    chk(pin_oe == 1'b1, "R8 master drive", pin_oe, 1);
    begin
      bit same = 1;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (if_clk != pin_out) same = 0;
      end
      chk(same, "R8 master if_clk", same, 1);
    end
  endtask

  task automatic t_mismatch();
    @(posedge clk); #1;
    fs_dir = 1'b0;
    @(negedge clk);
    // R9
    chk(dir_mismatch == 1'b0, "R9 flag registered", dir_mismatch, 0);
    @(negedge clk);
    chk(dir_mismatch == 1'b1, "R9 flag set", dir_mismatch, 1);
    @(posedge clk); #1;
    fs_dir = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(dir_mismatch == 1'b0, "R9 flag clear", dir_mismatch, 0);
  endtask

  task automatic t_strobe();
    int n = 0;
    bit ok = 1;
    logic prev;
    wr(word(1'b1, 1'b1, 8'd3));
    wait_stb("R10");
    prev = pin_out;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (rise_stb) n++;
      if (rise_stb != (pin_out && !prev)) ok = 0;
      prev = pin_out;
    end
    // R10: modulus 5 over 50 cycles gives 10 strobes
    chk(ok, "R10 strobe on edges", ok, 1);
    chk(n == 10, "R10 strobe count", n, 10);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_reserved();
    t_modulus(8'd2, 4, "R3 div2");
    t_modulus(8'd5, 7, "R3 div5");
    t_modulus(8'd253, 255, "R3 div253");
    t_modulus(8'd254, 256, "R3 div254");
    t_modulus(8'd0, 3, "R4 clamp");
    t_no_runt();
    t_disable();
    t_pins();
    t_mismatch();
    t_strobe();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%0d exp=done", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule